// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Controller

This block gates a set of differential clock outputs that are derived from one internal source clock. Each output is a true/complement pair with a separate drive enable for each leg. An active-low stop request, which may arrive at any time with no relation to the clock, parks the outputs that configuration marks as stoppable. Outputs that are not marked keep toggling, and any other clocks in the system are unaffected. Each stopped output parks in one of two ways. In the normal way the true leg is held driven high and the complement leg is released, so the pair reads high/low. In the high-impedance way both legs are released and read low through the external pull-downs.

The request is resynchronized on falling edges of the source clock, which are the rising edges of the internal complement clock. The stop-enable and high-impedance masks are captured at the moment a stop begins. Every change of gating is placed so that each output edge coincides with a source clock edge. As a result, neither entering nor leaving the parked state can produce a shortened or stretched pulse.

Top module: `diff_clk_stop`

## Requirements
- R1: While rst_ni is low and after its release, every pair runs: true_o follows clk_i, comp_o is its inverse, and both enables are 1. The request synchronizer clears to "no stop".
- R2: An output whose stop_en_i bit is 0 keeps toggling as in R10 while other outputs are parked.
- R3: stop_ni is sampled only on falling edges of clk_i, through two register stages. A low pulse on stop_ni that covers no falling edge has no effect on any output.
- R4: Once stop_ni is low, every stoppable output reaches its parked state within 2 to 6 falling edges of clk_i.
- R5: Normal park (hiz_i bit 0): true_o=1, true_en_o=1, comp_o=0, comp_en_o=0.
- R6: High-impedance park (hiz_i bit 1): true_o, comp_o, true_en_o and comp_en_o are all 0.
- R7: Once stop_ni returns high, every parked output is running again within 2 to 6 falling edges of clk_i.
- R8: Every change of true_o or comp_o happens at a clk_i edge, and no two changes of one output are closer than half a clk_i period. There are no runt pulses on entry to or exit from park.
- R9: stop_en_i and hiz_i are captured when a stop begins. Changes to them while outputs are stopped have no effect until the next stop.
- R10: While running, true_o equals clk_i, comp_o equals its inverse, and both enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Asynchronous stop request, active low |
| stop_en_i | input | N_OUT | Per-output stoppable mask |
| hiz_i | input | N_OUT | Per-output high-impedance park select |
| true_o | output | N_OUT | True leg level |
| comp_o | output | N_OUT | Complement leg level (0 when undriven) |
| true_en_o | output | N_OUT | True leg drive enable |
| comp_en_o | output | N_OUT | Complement leg drive enable |

## Verification
The bench records the time of every output transition and flags any change that is off a clock edge or that follows the previous change by less than half a period. A gate that switched its enable in the wrong clock phase would leave exactly that kind of sliver pulse at park entry or exit. Stop and resume latencies are measured in falling edges and must land inside the 2 to 6 window; a missing or extra synchronizer stage, or an enable updated on the wrong edge, moves the count or leaves a pair half-parked. A short stop glitch placed between falling edges must leave every output running, which catches a design that samples on the wrong edge or latches the level. Masks rewritten during a stop must not change the parked pattern until the following stop, which catches a design that reads the configuration live.

// File: rtl/diff_clk_stop_pkg.sv
`timescale 1ns/1ps
package diff_clk_stop_pkg;
  typedef enum logic [1:0] {
    PK_RUN   = 2'd0,
    PK_HIGH  = 2'd1,
    PK_FLOAT = 2'd2
  } park_e;
endpackage

// File: rtl/diff_clk_stop_sync.sv
`timescale 1ns/1ps
module diff_clk_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_ni,
  output logic req_o
);
  logic [STAGES-1:0] stage_q;

  // sampled on rising edge of the complement clock
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= 1'b0;
        else if (s == 0) stage_q[s] <= ~stop_ni;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign req_o = stage_q[STAGES-1];

  a_r3_two_stage: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(stage_q[STAGES-1]) |-> $past(stage_q[(STAGES > 1) ? STAGES-2 : 0]));
endmodule

// File: rtl/diff_clk_stop_ctrl.sv
`timescale 1ns/1ps
module diff_clk_stop_ctrl
  import diff_clk_stop_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [N_OUT-1:0]         stop_en_i,
  input  logic [N_OUT-1:0]         hiz_i,
  output park_e [N_OUT-1:0]        mode_o
);
  logic             stopped_q;
  logic [N_OUT-1:0] mask_q;
  logic [N_OUT-1:0] hiz_q;

  // masks frozen at stop entry
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_q <= 1'b0;
      mask_q    <= '0;
      hiz_q     <= '0;
    end else if (req_i && !stopped_q) begin
      stopped_q <= 1'b1;
      mask_q    <= stop_en_i;
      hiz_q     <= hiz_i;
    end else if (!req_i) begin
      stopped_q <= 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_mode
      always_comb begin
        if (!(stopped_q && mask_q[i])) mode_o[i] = PK_RUN;
        else if (hiz_q[i])             mode_o[i] = PK_FLOAT;
        else                           mode_o[i] = PK_HIGH;
      end
      a_r2_unmasked_runs: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !mask_q[i] |-> (mode_o[i] == PK_RUN));
    end
  endgenerate

  a_r3_entry_after_req: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(stopped_q) |-> $past(req_i));
  a_r9_mask_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (stopped_q && $past(stopped_q)) |-> ($stable(mask_q) && $stable(hiz_q)));
endmodule

// File: rtl/diff_clk_stop_leg.sv
`timescale 1ns/1ps
module diff_clk_stop_leg
  import diff_clk_stop_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  park_e mode_i,
  output logic  true_o,
  output logic  comp_o,
  output logic  true_en_o,
  output logic  comp_en_o
);
  logic hi_q;    // hold true leg high, moves while clk_i is high
  logic coff_q;  // gate complement, moves while clk_i is high
  logic lo_park; // float true leg, moves while clk_i is low

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      coff_q <= 1'b0;
    end else begin
      hi_q   <= (mode_i == PK_HIGH);
      coff_q <= (mode_i != PK_RUN);
    end
  end

  assign lo_park   = (mode_i == PK_FLOAT);
  assign true_o    = (clk_i | hi_q) & ~lo_park;
  assign comp_o    = ~clk_i & ~coff_q;
  assign true_en_o = ~lo_park;
  assign comp_en_o = ~coff_q;

  // sampled values at posedge reflect the low phase just ending
  a_r10_run_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PK_RUN && !hi_q && !coff_q) |->
      (!true_o && comp_o && true_en_o && comp_en_o));
  a_r5_park_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q |-> (true_o && !comp_o && true_en_o && !comp_en_o));
  a_r6_park_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PK_FLOAT && coff_q) |->
      (!true_o && !comp_o && !true_en_o && !comp_en_o));
endmodule

// File: rtl/diff_clk_stop.sv
`timescale 1ns/1ps
module diff_clk_stop
  import diff_clk_stop_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  input  logic [N_OUT-1:0] stop_en_i,
  input  logic [N_OUT-1:0] hiz_i,
  output logic [N_OUT-1:0] true_o,
  output logic [N_OUT-1:0] comp_o,
  output logic [N_OUT-1:0] true_en_o,
  output logic [N_OUT-1:0] comp_en_o
);
  logic                req;
  park_e [N_OUT-1:0]   mode;

  diff_clk_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_ni (stop_ni),
    .req_o   (req)
  );

  diff_clk_stop_ctrl #(.N_OUT(N_OUT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .stop_en_i (stop_en_i),
    .hiz_i     (hiz_i),
    .mode_o    (mode)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_leg
      diff_clk_stop_leg u_leg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode[i]),
        .true_o    (true_o[i]),
        .comp_o    (comp_o[i]),
        .true_en_o (true_en_o[i]),
        .comp_en_o (comp_en_o[i])
      );
    end
  endgenerate
endmodule

// File: tb/diff_clk_stop_test.sv
`timescale 1ns/1ps
module diff_clk_stop_test;
  localparam int N = 4;
  localparam int HALF = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         stop_ni = 1'b1;
  logic [N-1:0] stop_en = '0;
  logic [N-1:0] hiz = '0;
  logic [N-1:0] true_o, comp_o, true_en_o, comp_en_o;

  int checks = 0;
  int errors = 0;
  int runt_err = 0;

  always #HALF clk = ~clk;

  diff_clk_stop #(.N_OUT(N), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .stop_ni(stop_ni),
    .stop_en_i(stop_en), .hiz_i(hiz),
    .true_o(true_o), .comp_o(comp_o),
    .true_en_o(true_en_o), .comp_en_o(comp_en_o)
  );

  // R8 edge-timing monitor
  logic [N-1:0] prev_t = 'x, prev_c = 'x;
  longint last_t [N];
  longint last_c [N];
  initial for (int i = 0; i < N; i++) begin last_t[i] = -100; last_c[i] = -100; end

  always @(true_o or comp_o) begin
    for (int i = 0; i < N; i++) begin
      if (true_o[i] !== prev_t[i]) begin
        if (($time % HALF) != 0 || ($time - last_t[i]) < HALF) begin
          runt_err++;
          $display("FAIL R8 true_o[%0d] edge at %0t, previous %0d, expected aligned >= %0d apart", i, $time, last_t[i], HALF);
        end
        last_t[i] = $time;
      end
      if (comp_o[i] !== prev_c[i]) begin
        if (($time % HALF) != 0 || ($time - last_c[i]) < HALF) begin
          runt_err++;
          $display("FAIL R8 comp_o[%0d] edge at %0t, previous %0d, expected aligned >= %0d apart", i, $time, last_c[i], HALF);
        end
        last_c[i] = $time;
      end
    end
    prev_t = true_o;
    prev_c = comp_o;
  end

  function automatic logic [3:0] exp_bits(logic run, logic hz, logic ph);
    if (run)     return {ph, ~ph, 1'b1, 1'b1};
    else if (hz) return 4'b0000;
    else         return 4'b1010;
  endfunction

  function automatic logic match(logic ph, logic [N-1:0] runm, logic [N-1:0] hzm);
    for (int i = 0; i < N; i++)
      if ({true_o[i], comp_o[i], true_en_o[i], comp_en_o[i]} !== exp_bits(runm[i], hzm[i], ph))
        return 1'b0;
    return 1'b1;
  endfunction

  task automatic half_chk(logic ph, logic [N-1:0] runm, logic [N-1:0] hzm, string tag);
    checks++;
    if (!match(ph, runm, hzm)) begin
      errors++;
      $display("FAIL %s phase=%0b t=%b c=%b ten=%b cen=%b expected run=%b hiz=%b",
               tag, ph, true_o, comp_o, true_en_o, comp_en_o, runm, hzm);
    end
  endtask

  task automatic cyc(int n, logic [N-1:0] runm, logic [N-1:0] hzm, string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2; half_chk(1'b1, runm, hzm, tag);
      @(negedge clk); #2; half_chk(1'b0, runm, hzm, tag);
    end
  endtask

  task automatic wait_state(logic [N-1:0] runm, logic [N-1:0] hzm, string tag);
    int n = 0;
    logic ok = 1'b0;
    while (!ok && n < 10) begin
      @(negedge clk); #2;
      n++;
      ok = match(1'b0, runm, hzm);
    end
    checks++;
    if (!ok || n < 2 || n > 6) begin
      errors++;
      $display("FAIL %s latency %0d falling edges reached=%0b, expected 2..6", tag, n, ok);
    end
  endtask

  task automatic t_reset;
    cyc(2, '1, '0, "R1 during reset");
    @(negedge clk); #2; rst_ni = 1'b1;
    cyc(3, '1, '0, "R1 after reset R10");
  endtask

  task automatic t_stop_all_high;
    stop_en = '1; hiz = '0;
    @(negedge clk); #1; stop_ni = 1'b0;
    wait_state('0, '0, "R4 stop latency");
    cyc(4, '0, '0, "R5 normal park");
    @(negedge clk); #1; stop_ni = 1'b1;
    wait_state('1, '0, "R7 resume latency");
    cyc(3, '1, '0, "R10 running after resume");
  endtask

  task automatic t_partial;
    stop_en = 4'b0101; hiz = 4'b0100;
    @(negedge clk); #1; stop_ni = 1'b0;
    wait_state(4'b1010, 4'b0100, "R4 partial stop latency");
    cyc(4, 4'b1010, 4'b0100, "R2 R6 mixed park");
    @(negedge clk); #1; stop_ni = 1'b1;
    wait_state('1, '0, "R7 partial resume latency");
    cyc(2, '1, '0, "R10 after partial");
  endtask

  task automatic t_glitch;
    stop_en = '1; hiz = '0;
    @(posedge clk); #1; stop_ni = 1'b0;
    #3; stop_ni = 1'b1;
    cyc(5, '1, '0, "R3 glitch between falling edges ignored");
  endtask

  task automatic t_mask_change;
    stop_en = 4'b0011; hiz = 4'b0000;
    @(negedge clk); #1; stop_ni = 1'b0;
    wait_state(4'b1100, '0, "R4 stop before mask change");
    stop_en = 4'b1100; hiz = 4'b1111;
    cyc(4, 4'b1100, '0, "R9 mask change while stopped ignored");
    @(negedge clk); #1; stop_ni = 1'b1;
    wait_state('1, '0, "R7 resume after mask change");
    cyc(2, '1, '0, "R10 running between stops");
    @(negedge clk); #1; stop_ni = 1'b0;
    wait_state(4'b0011, 4'b1100, "R9 new masks at next stop");
    cyc(3, 4'b0011, 4'b1100, "R6 R2 float park new masks");
    @(negedge clk); #1; stop_ni = 1'b1;
    wait_state('1, '0, "R7 final resume");
    cyc(2, '1, '0, "R10 final run");
  endtask

  initial begin
    t_reset;
    t_stop_all_high;
    t_partial;
    t_glitch;
    t_mask_change;
    checks++;
    if (runt_err != 0) begin
      errors++;
      $display("FAIL R8 runt/misaligned edges %0d expected 0", runt_err);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule